// File: doc/BRIEF.md
# Dual-Register DAC Update Controller

This block sits in front of a bank of DAC channels and decides which code each channel's output latch presents. Every channel owns two data registers, called A and B, and one output latch. A parallel write port stores a code into either register of a chosen channel. An active-low load input chooses the update mode. When it is held low, writes pass straight through to the outputs. When it is held high, writes only stage codes, and a later falling edge publishes every channel at once.

A trigger input turns the bank into a square-wave source. A rising trigger edge arms toggle mode. Each later falling edge swaps the active register of every channel and reloads every output from the newly active register. A status output reports which register is active. An asynchronous active-low clear drives all outputs to code zero at once, without waiting for a clock.

The load, trigger and clear inputs come from outside the clock domain. Each one passes through a two-stage synchronizer before its edges are detected. The channel count and the code width are parameters.

Top module: `dac_dual_reg_ctrl`

## Requirements
- R1: After reset is released, every output code reads zero and `statusB` reads 0, meaning register A is active. Both registers of every channel hold zero, toggle mode is disarmed, and a load falling edge issued at that point publishes zeros.
- R2: A write with `wrValid` high stores `wrData` at the clock edge that samples it. It goes to channel `wrChan`, into register A when `wrSelB` is 0 and into register B when `wrSelB` is 1.
- R3: While the synchronized load input is low, a write to the active register of a channel changes that channel's output at the same clock edge that stores it. A write to the inactive register leaves the output unchanged.
- R4: While load is high, writes leave the outputs unchanged. A falling edge on `loadN` copies the active register of every channel into its output in one cycle, on the third clock edge after the fall.
- R5: While `clearN` is low, every output reads zero at once, without any clock edge. Writes made during the clear still reach the registers. After `clearN` rises, the outputs stay zero until the next update.
- R6: A rising edge on `trigIn` arms toggle mode and changes neither the outputs nor `statusB`. Once armed, toggle mode stays armed until reset.
- R7: Once toggle mode is armed, each falling edge on `trigIn` inverts the active register for all channels. The same edge loads every output from its newly active register on the third clock edge after the fall, whatever the load level is.
- R8: `statusB` is 0 while register A is active and 1 while register B is active. It changes in the same cycle as the outputs on a toggle.
- R9: A write whose `wrChan` is not below the channel count changes no register and no output.
- R10: In toggle mode, a write to the active register follows the load rule of R3 and R4. A write to the inactive register shows up only at the next toggle.
- R11: If a write to a channel's newly active register lands on the same clock edge as a toggle, that channel's output takes the written code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset of the whole block |
| clearN | input | 1 | Asynchronous active-low clear of all output codes |
| loadN | input | 1 | Active-low load level; its falling edge publishes staged codes |
| trigIn | input | 1 | Toggle trigger; rise arms, each later fall swaps registers |
| wrValid | input | 1 | Write strobe for the register port |
| wrChan | input | CH_W | Channel index of the write |
| wrSelB | input | 1 | Register select: 0 writes A, 1 writes B |
| wrData | input | CODE_W | Code to store |
| dacOut | output | NUM_CH*CODE_W | Output latch codes, channel 0 in the low bits |
| statusB | output | 1 | Active register flag: 0 for A, 1 for B |

## Verification
A register write and a toggle can both act on an output latch in the same cycle, and the write must win when it targets the register that the toggle makes active. The bench times a write so that it is sampled on exactly the third clock edge after a trigger falling edge, the same edge on which the toggle strobe acts. It then expects the written code on that channel and the newly active register's old contents on every other channel. The status flag must flip on that same edge.

// File: rtl/dac_dual_pkg.sv
`timescale 1ns/1ps
package dac_dual_pkg;

  // Strobes passed from the control unit to the datapath, valid for one cycle
  typedef struct packed {
    logic loadAll;   // publish the active register of every channel
    logic toggle;    // swap the active register and publish it
    logic passThru;  // load level is low: writes to the active register go through
    logic hold;      // synchronized clear is still low: keep outputs at zero
  } dacStrobe_t;

  localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/dac_sync.sv
`timescale 1ns/1ps
module dac_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= RST_VAL;
    end else begin
      stageQ[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/dac_dual_ctrl.sv
`timescale 1ns/1ps
module dac_dual_ctrl
  import dac_dual_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadSync,
  input  logic       trigSync,
  input  logic       clearSync,
  output dacStrobe_t strb,
  output logic       activeSel,
  output logic       armed
);

  logic loadPrev;
  logic trigPrev;
  logic trigRise;
  logic trigFall;
  logic toggleNow;

  // Edge detection on the synchronized levels
  assign trigRise  = trigSync & ~trigPrev;
  assign trigFall  = ~trigSync & trigPrev;
  assign toggleNow = trigFall & armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPrev  <= 1'b1;
      trigPrev  <= 1'b0;
      armed     <= 1'b0;
      activeSel <= 1'b0;
    end else begin
      loadPrev <= loadSync;
      trigPrev <= trigSync;
      if (trigRise)  armed     <= 1'b1;
      if (toggleNow) activeSel <= ~activeSel;
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadAll  = loadPrev & ~loadSync;
    strb.toggle   = toggleNow;
    strb.passThru = ~loadSync;
    strb.hold     = ~clearSync;
  end

endmodule

// File: rtl/dac_dual_path.sv
`timescale 1ns/1ps
module dac_dual_path
  import dac_dual_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 12,
  parameter int CH_W   = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clearN,
  input  dacStrobe_t               strb,
  input  logic                     activeSel,
  input  logic                     wrValid,
  input  logic [CH_W-1:0]          wrChan,
  input  logic                     wrSelB,
  input  logic [CODE_W-1:0]        wrData,
  output logic [NUM_CH*CODE_W-1:0] dacOut
);

  logic wrOk;
  logic selNext;

  // An index at or above the channel count matches no channel
  assign wrOk    = wrValid && (int'(wrChan) < NUM_CH);
  // Register that will drive the outputs after this edge
  assign selNext = strb.toggle ? ~activeSel : activeSel;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CODE_W-1:0] regA, regB, nextA, nextB, srcCode, latchQ;
    logic hitA, hitB, hitNext, update;

    assign hitA    = wrOk && (int'(wrChan) == ch) && !wrSelB;
    assign hitB    = wrOk && (int'(wrChan) == ch) &&  wrSelB;
    assign nextA   = hitA ? wrData : regA;
    assign nextB   = hitB ? wrData : regB;
    assign srcCode = selNext ? nextB : nextA;
    assign hitNext = selNext ? hitB : hitA;
    assign update  = strb.toggle | strb.loadAll | (strb.passThru & hitNext);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regA <= '0;
        regB <= '0;
      end else begin
        if (hitA) regA <= wrData;
        if (hitB) regB <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN or negedge clearN) begin
      if (!rstN || !clearN) latchQ <= '0;
      else if (strb.hold)   latchQ <= '0;
      else if (update)      latchQ <= srcCode;
    end

    assign dacOut[ch*CODE_W +: CODE_W] = latchQ;
  end

endmodule

// File: rtl/dac_dual_reg_ctrl.sv
`timescale 1ns/1ps
module dac_dual_reg_ctrl
  import dac_dual_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 12,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clearN,
  input  logic                     loadN,
  input  logic                     trigIn,
  input  logic                     wrValid,
  input  logic [CH_W-1:0]          wrChan,
  input  logic                     wrSelB,
  input  logic [CODE_W-1:0]        wrData,
  output logic [NUM_CH*CODE_W-1:0] dacOut,
  output logic                     statusB
);

  logic [2:0] syncIn, syncQ;
  dacStrobe_t strb;
  logic       activeSel;
  logic       ctrlArmed;

  assign syncIn = {clearN, loadN, trigIn};

  dac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(syncIn), .syncOut(syncQ)
  );

  dac_dual_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .loadSync(syncQ[1]), .trigSync(syncQ[0]), .clearSync(syncQ[2]),
    .strb(strb), .activeSel(activeSel), .armed(ctrlArmed)
  );

  dac_dual_path #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .CH_W(CH_W)) path_i (
    .clk(clk), .rstN(rstN), .clearN(clearN), .strb(strb),
    .activeSel(activeSel), .wrValid(wrValid), .wrChan(wrChan),
    .wrSelB(wrSelB), .wrData(wrData), .dacOut(dacOut)
  );

  assign statusB = activeSel;

endmodule

// File: rtl/dac_dual_checker.sv
`timescale 1ns/1ps
module dac_dual_checker
  import dac_dual_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 12,
  parameter int CH_W   = 3
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     clearN,
  input logic                     wrValid,
  input logic [CH_W-1:0]          wrChan,
  input logic [NUM_CH*CODE_W-1:0] dacOut,
  input logic                     statusB,
  input logic                     armed,
  input dacStrobe_t               strb
);

  // R5: an asserted clear zeroes every output regardless of clocking
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !clearN |-> (dacOut == '0));

  // R6: once armed, toggle mode stays armed
  assert_arm_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> armed);

  // R7: the active register only moves after arming
  assert_status_needs_arm_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusB) |-> $past(armed));

  // R4: without a strobe or write, the outputs hold
  assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clearN && !strb.loadAll && !strb.toggle && !wrValid) |=> (!clearN || $stable(dacOut)));

  // R9: an out-of-range write touches no output
  assert_range_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clearN && wrValid && (int'(wrChan) >= NUM_CH) && !strb.loadAll && !strb.toggle)
      |=> (!clearN || $stable(dacOut)));

endmodule

bind dac_dual_reg_ctrl dac_dual_checker #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .CH_W(CH_W)) chk_i (
  .clk(clk), .rstN(rstN), .clearN(clearN), .wrValid(wrValid), .wrChan(wrChan),
  .dacOut(dacOut), .statusB(statusB), .armed(ctrlArmed), .strb(strb)
);

// File: tb/dac_dual_reg_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_dual_reg_ctrl_tb_top;

  localparam int NCH = 5;
  localparam int W   = 12;
  localparam int CW  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearN = 1'b1;
  logic loadN = 1'b1;
  logic trigIn = 1'b0;
  logic wrValid = 1'b0;
  logic wrSelB = 1'b0;
  logic [CW-1:0] wrChan = '0;
  logic [W-1:0]  wrData = '0;
  logic [NCH*W-1:0] dacOut;
  logic statusB;

  always #2.5 clk = ~clk;

  dac_dual_reg_ctrl #(.NUM_CH(NCH), .CODE_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .clearN(clearN), .loadN(loadN), .trigIn(trigIn),
    .wrValid(wrValid), .wrChan(wrChan), .wrSelB(wrSelB), .wrData(wrData),
    .dacOut(dacOut), .statusB(statusB)
  );

  typedef struct {
    logic [NCH*W-1:0] outs;
    logic             st;
    string            tag;
  } expItem_t;

  expItem_t sbq[$];
  int checks = 0;
  int errors = 0;

  // Reference model built from the requirements
  logic [W-1:0] mA [NCH];
  logic [W-1:0] mB [NCH];
  logic [W-1:0] mOut [NCH];
  logic mAct = 1'b0;
  logic mLoadLow = 1'b0;
  logic mClear = 1'b0;

  function automatic logic [NCH*W-1:0] modelVec();
    logic [NCH*W-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*W +: W] = mOut[c];
    return v;
  endfunction

  task automatic compare(input logic [NCH*W-1:0] expOuts, input logic expSt, input string tag);
    checks++;
    if (dacOut !== expOuts || statusB !== expSt) begin
      errors++;
      $display("FAIL %s: outs=%h status=%b expected outs=%h status=%b",
               tag, dacOut, statusB, expOuts, expSt);
    end
  endtask

  task automatic pushExp(input string tag);
    expItem_t it;
    it.outs = modelVec();
    it.st   = mAct;
    it.tag  = tag;
    sbq.push_back(it);
  endtask

  // Monitor: pops one expectation per falling clock edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      expItem_t it;
      it = sbq.pop_front();
      compare(it.outs, it.st, it.tag);
    end
  end

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic modelWrite(input int ch, input logic selB, input logic [W-1:0] d);
    if (ch < NCH) begin
      if (selB) mB[ch] = d; else mA[ch] = d;
      if (mLoadLow && !mClear && selB == mAct) mOut[ch] = d;
    end
  endtask

  task automatic modelPublish();
    for (int c = 0; c < NCH; c++) mOut[c] = mAct ? mB[c] : mA[c];
  endtask

  task automatic doWrite(input int ch, input logic selB, input logic [W-1:0] d);
    wrValid = 1'b1;
    wrChan  = CW'(ch);
    wrSelB  = selB;
    wrData  = d;
    waitEdges(1);
    wrValid = 1'b0;
    modelWrite(ch, selB, d);
  endtask

  task automatic setLoad(input logic lvl);
    logic wasHigh;
    wasHigh = loadN;
    loadN = lvl;
    waitEdges(4);
    mLoadLow = !lvl;
    if (wasHigh && !lvl && !mClear) modelPublish();
  endtask

  task automatic trigRise();
    trigIn = 1'b1;
    waitEdges(4);
  endtask

  task automatic trigFall();
    trigIn = 1'b0;
    waitEdges(4);
    mAct = ~mAct;
    modelPublish();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      mA[c] = '0; mB[c] = '0; mOut[c] = '0;
    end
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(2);

    // R1: reset state
    pushExp("R1 reset state"); waitEdges(1);
    setLoad(1'b0); setLoad(1'b1);
    pushExp("R1 registers zero after reset"); waitEdges(1);

    // R2 / R4: staged writes with load high
    doWrite(0, 1'b0, 12'h123);
    doWrite(4, 1'b0, 12'hABC);
    doWrite(0, 1'b1, 12'h456);
    doWrite(4, 1'b1, 12'h789);
    doWrite(2, 1'b0, 12'hFFF);
    pushExp("R4 writes staged, outputs unchanged"); waitEdges(1);

    // R9: out-of-range index
    doWrite(6, 1'b0, 12'h555);
    pushExp("R9 out-of-range write ignored"); waitEdges(1);

    // R2 / R4: falling load publishes all
    setLoad(1'b0);
    pushExp("R4 load fall publishes register A codes (R2)"); waitEdges(1);

    // R3: pass-through with load low
    doWrite(1, 1'b0, 12'h321);
    pushExp("R3 write to active register passes through"); waitEdges(1);
    doWrite(1, 1'b1, 12'h0F0);
    pushExp("R3 write to inactive register holds output"); waitEdges(1);

    // R5: asynchronous clear
    clearN = 1'b0; mClear = 1'b1;
    #1;
    for (int c = 0; c < NCH; c++) mOut[c] = '0;
    compare(modelVec(), mAct, "R5 clear acts without a clock edge");
    doWrite(3, 1'b0, 12'h777);
    pushExp("R5 write during clear keeps outputs zero"); waitEdges(1);
    clearN = 1'b1;
    waitEdges(4);
    mClear = 1'b0;
    pushExp("R5 outputs stay zero after clear release"); waitEdges(1);
    setLoad(1'b1); setLoad(1'b0);
    pushExp("R5 registers kept through clear"); waitEdges(1);

    // R6: arming
    trigRise();
    pushExp("R6 trigger rise only arms"); waitEdges(1);

    // R7 / R8: toggle to B
    trigFall();
    pushExp("R7 toggle to register B, R8 status 1"); waitEdges(1);

    // R10: writes in toggle mode with load low
    doWrite(2, 1'b1, 12'h2A2);
    pushExp("R10 active register write passes through"); waitEdges(1);
    doWrite(0, 1'b0, 12'h999);
    pushExp("R10 inactive register write held"); waitEdges(1);
    trigRise();
    trigFall();
    pushExp("R10 inactive write seen at toggle, R8 status 0"); waitEdges(1);

    // R11: write lands on the toggle edge
    trigRise();
    trigIn = 1'b0;
    waitEdges(2);
    wrValid = 1'b1; wrChan = CW'(4); wrSelB = 1'b1; wrData = 12'h5C5;
    waitEdges(1);
    wrValid = 1'b0;
    mB[4] = 12'h5C5;
    mAct = ~mAct;
    modelPublish();
    pushExp("R11 write coinciding with toggle wins"); waitEdges(1);

    // R10 with load high in toggle mode
    setLoad(1'b1);
    doWrite(0, 1'b1, 12'h111);
    pushExp("R10 staged write in toggle mode held"); waitEdges(1);
    setLoad(1'b0);
    pushExp("R10 load fall in toggle mode publishes"); waitEdges(1);

    waitEdges(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule